// File: doc/BRIEF.md
# Address-Line Clamp Remapper

This block sits between a bus master and an external SRAM port and gives each task a private view of a 512 kB memory region based at bus address 0x6000_0000. It translates addresses without page tables. Instead, it holds six upper address lines of the region, bits 13 through 18, at fixed values. Every other bit of the bus address is passed through unchanged. Clamping the top k lines shrinks the visible memory to a power-of-two window. That window repeats across the whole region, and the clamped values pick which physical slice of the chip it shows.

Each of the eight table entries stores a 6-bit enable mask and a 6-bit value vector. A context-switch strobe loads one entry as the live mapping. An interrupt-context flag bypasses translation entirely. A DMA lock input freezes the live mapping: any change requested while the lock is held is kept as pending and takes effect once the lock drops.

Top module: `line_clamp_remap`

## Requirements
- R1: After a synchronous active-low reset, the active task is 0, every table entry is all-pass (enable mask 0), and `phys_addr` equals `bus_addr` for every address.
- R2: For an address inside 0x6000_0000..0x6007_FFFF with `irq_ctx` low, bit 13+i of `phys_addr` (i = 0..5) equals bit i of the live value when bit i of the live enable is 1, and otherwise equals `bus_addr[13+i]`. All other bits equal `bus_addr`.
- R3: Clamping bit 18 low maps 0x6004_0000 to 0x6000_0000. Clamping bit 18 high maps 0x6000_1234 to 0x6004_1234. Clamping all six bits folds every 8 kB block onto the single block that the value selects.
- R4: An address outside 0x6000_0000..0x6007_FFFF leaves `phys_addr` equal to `bus_addr`, with `remap_hit` low.
- R5: While `irq_ctx` is high, `phys_addr` equals `bus_addr` and `remap_hit` is low.
- R6: A `ctx_sw` strobe with `dma_lock` low makes `active_tid` equal `ctx_tid` on the next cycle and loads that entry as the live mapping.
- R7: While `dma_lock` is high, `active_tid` and the live mapping do not change. A switch requested under the lock is pending and is applied at the first clock edge with the lock low. The newest requested ID wins, and a fresh switch at that same edge overrides the pending one.
- R8: A table write to the entry of the active task refreshes the live mapping on the next cycle when `dma_lock` is low. When the lock is high, the refresh is held and applied at release.
- R9: `remap_hit` is high exactly when the address is inside the region, `irq_ctx` is low and the live enable mask is nonzero.
- R10: A switch and a table write to the same target entry in the same cycle load the newly written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Address from the bus master |
| irq_ctx | input | 1 | Interrupt context: bypass translation |
| ctx_sw | input | 1 | Context-switch strobe |
| ctx_tid | input | 3 | Task ID to switch to |
| dma_lock | input | 1 | Hold off all mapping changes |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 3 | Table entry to write |
| tbl_en | input | 6 | Clamp enable mask for bits 18..13 |
| tbl_val | input | 6 | Clamp value for bits 18..13 |
| phys_addr | output | 32 | Translated address to the SRAM port |
| remap_hit | output | 1 | A clamp was applied to this address |
| active_tid | output | 3 | Task whose mapping is live |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 512 kB region at 0x6000_0000, eight tasks and six clamp lines. At that size every entry and every clamp line can be driven directly. Window sizes from 256 kB down to the single 8 kB block are all covered, as are addresses just outside both ends of the region. The same size lets the bench line up lock, pending-switch and same-cycle write/switch collisions on chosen edges, with a behavioural model checking every cycle.

// File: rtl/remap_pkg.sv
// Shared types for the address-line clamp remapper.
// Assumes exactly six clamped lines; the struct width follows OVR_W.
package remap_pkg;
    localparam int OVR_W = 6;

    typedef struct packed {
        logic [OVR_W-1:0] en;
        logic [OVR_W-1:0] val;
    } ovr_t;

    localparam ovr_t OVR_PASS = '0;
endpackage

// File: rtl/remap_table.sv
// Per-task clamp table with one write port and one forwarding read port.
// The read port returns the data being written this cycle when the
// indices match, so a load in the same cycle sees the new contents.
module remap_table
    import remap_pkg::*;
#(
    parameter int TASKS = 8,
    parameter int TID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [TID_W-1:0] widx,
    input  ovr_t             wdata,
    input  logic [TID_W-1:0] rtid,
    output ovr_t             rdata
);
    ovr_t ent [TASKS];

    // Store entries; reset to all-pass.
    always_ff @(posedge clk) begin
        for (int i = 0; i < TASKS; i++) begin
            if (!rst_n)
                ent[i] <= OVR_PASS;
            else if (we && widx == TID_W'(i))
                ent[i] <= wdata;
        end
    end

    // Read with forwarding of a same-cycle write.
    always_comb begin
        rdata = ent[rtid];
        if (we && widx == rtid)
            rdata = wdata;
    end
endmodule

// File: rtl/remap_ctx.sv
// Context controller: owns the active task ID, the live clamp setting and a
// pending-change slot used while the DMA lock holds the mapping frozen.
// Assumes table reads are forwarded (see remap_table).
module remap_ctx
    import remap_pkg::*;
#(
    parameter int TID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctx_sw,
    input  logic [TID_W-1:0] ctx_tid,
    input  logic             dma_lock,
    input  logic             tbl_we,
    input  logic [TID_W-1:0] tbl_idx,
    output logic [TID_W-1:0] rd_tid,
    input  ovr_t             rd_data,
    output logic [TID_W-1:0] act_tid,
    output ovr_t             live
);
    logic             pend_q, pend_d;
    logic [TID_W-1:0] ptid_q, ptid_d;
    logic             load;

    // Decide whether a new mapping loads this cycle and what stays pending.
    always_comb begin
        pend_d = pend_q;
        ptid_d = ptid_q;
        load   = 1'b0;
        rd_tid = act_tid;
        if (ctx_sw) begin
            if (dma_lock) begin
                pend_d = 1'b1;
                ptid_d = ctx_tid;
            end else begin
                load   = 1'b1;
                rd_tid = ctx_tid;
                pend_d = 1'b0;
            end
        end else if (dma_lock) begin
            if (tbl_we && tbl_idx == act_tid && !pend_q) begin
                pend_d = 1'b1;
                ptid_d = act_tid;
            end
        end else if (pend_q) begin
            load   = 1'b1;
            rd_tid = ptid_q;
            pend_d = 1'b0;
        end else if (tbl_we && tbl_idx == act_tid) begin
            load = 1'b1;
        end
    end

    // Register active task, live mapping and pending slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_tid <= '0;
            live    <= OVR_PASS;
            pend_q  <= 1'b0;
            ptid_q  <= '0;
        end else begin
            pend_q <= pend_d;
            ptid_q <= ptid_d;
            if (load) begin
                act_tid <= rd_tid;
                live    <= rd_data;
            end
        end
    end
endmodule

// File: rtl/remap_xlate.sv
// Combinational address translator: inside the region and outside interrupt
// context, each clamp line takes the live value where enabled, else the bus bit.
// Assumes REGION_LG > OVR_W and ADDR_W > REGION_LG.
module remap_xlate
    import remap_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6000_0000,
    parameter int              REGION_LG = 19
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              irq_ctx,
    input  ovr_t              live,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              remap_hit
);
    localparam int LOW_BIT = REGION_LG - OVR_W;

    logic [OVR_W-1:0] clamped;
    logic             in_win;
    logic             apply;

    // Per-line select between the live value and the bus bit.
    for (genvar b = 0; b < OVR_W; b++) begin : g_line
        assign clamped[b] = live.en[b] ? live.val[b] : bus_addr[LOW_BIT+b];
    end

    // Region decode and output assembly.
    always_comb begin
        in_win    = bus_addr[ADDR_W-1:REGION_LG] == BASE_ADDR[ADDR_W-1:REGION_LG];
        apply     = in_win && !irq_ctx;
        phys_addr = bus_addr;
        if (apply)
            phys_addr = {bus_addr[ADDR_W-1:REGION_LG], clamped, bus_addr[LOW_BIT-1:0]};
        remap_hit = apply && (|live.en);
    end
endmodule

// File: rtl/line_clamp_remap.sv
// Top of the address-line clamp remapper: table, context controller and
// translator. Assumes the region base is aligned to 2**REGION_LG.
module line_clamp_remap
    import remap_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6000_0000,
    parameter int                REGION_LG = 19,
    parameter int                TASKS     = 8,
    localparam int               TID_W     = $clog2(TASKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              irq_ctx,
    input  logic              ctx_sw,
    input  logic [TID_W-1:0]  ctx_tid,
    input  logic              dma_lock,
    input  logic              tbl_we,
    input  logic [TID_W-1:0]  tbl_idx,
    input  logic [OVR_W-1:0]  tbl_en,
    input  logic [OVR_W-1:0]  tbl_val,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              remap_hit,
    output logic [TID_W-1:0]  active_tid
);
    ovr_t             wdata;
    ovr_t             rd_data;
    ovr_t             live;
    logic [TID_W-1:0] rd_tid;

    assign wdata = '{en: tbl_en, val: tbl_val};

    remap_table #(.TASKS(TASKS), .TID_W(TID_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wdata(wdata),
        .rtid(rd_tid), .rdata(rd_data)
    );

    remap_ctx #(.TID_W(TID_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .ctx_sw(ctx_sw), .ctx_tid(ctx_tid),
        .dma_lock(dma_lock), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .rd_tid(rd_tid), .rd_data(rd_data), .act_tid(active_tid), .live(live)
    );

    remap_xlate #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REGION_LG(REGION_LG)) u_xl (
        .bus_addr(bus_addr), .irq_ctx(irq_ctx), .live(live),
        .phys_addr(phys_addr), .remap_hit(remap_hit)
    );
endmodule

// File: rtl/remap_chk.sv
// Checker for line_clamp_remap, attached by bind. Observes ports only.
module remap_chk #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6000_0000,
    parameter int                REGION_LG = 19,
    parameter int                TID_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq_ctx,
    input logic              ctx_sw,
    input logic [TID_W-1:0]  ctx_tid,
    input logic              dma_lock,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              remap_hit,
    input logic [TID_W-1:0]  active_tid
);
    localparam int LOW_BIT = REGION_LG - 6;

    logic outside;
    assign outside = bus_addr[ADDR_W-1:REGION_LG] != BASE_ADDR[ADDR_W-1:REGION_LG];

    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> (phys_addr == bus_addr && !remap_hit)); // R4
    AST_IRQ_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ctx |-> (phys_addr == bus_addr && !remap_hit)); // R5
    AST_UNTOUCHED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[LOW_BIT-1:0] == bus_addr[LOW_BIT-1:0]
        && phys_addr[ADDR_W-1:REGION_LG] == bus_addr[ADDR_W-1:REGION_LG]); // R2
    AST_SWITCH_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_sw && !dma_lock) |=> active_tid == $past(ctx_tid)); // R6
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        dma_lock |=> $stable(active_tid)); // R7
endmodule

bind line_clamp_remap remap_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REGION_LG(REGION_LG), .TID_W(TID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .irq_ctx(irq_ctx),
    .ctx_sw(ctx_sw), .ctx_tid(ctx_tid), .dma_lock(dma_lock),
    .phys_addr(phys_addr), .remap_hit(remap_hit), .active_tid(active_tid)
);

// File: tb/line_clamp_remap_test.sv
module line_clamp_remap_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_addr;
    logic        irq_ctx, ctx_sw, dma_lock, tbl_we;
    logic [2:0]  ctx_tid, tbl_idx;
    logic [5:0]  tbl_en, tbl_val;
    logic [31:0] phys_addr;
    logic        remap_hit;
    logic [2:0]  active_tid;

    int checks = 0;
    int errors = 0;

    // model state
    int m_en[8], m_val[8];
    int l_en, l_val, m_act, m_pend, m_ptid;

    always #5 clk = ~clk;

    line_clamp_remap uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .irq_ctx(irq_ctx),
        .ctx_sw(ctx_sw), .ctx_tid(ctx_tid), .dma_lock(dma_lock),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_en(tbl_en), .tbl_val(tbl_val),
        .phys_addr(phys_addr), .remap_hit(remap_hit), .active_tid(active_tid)
    );

    function automatic logic [31:0] exp_phys(input logic [31:0] a);
        logic [31:0] r;
        r = a;
        if (a >= 32'h6000_0000 && a <= 32'h6007_FFFF && !irq_ctx) begin
            for (int i = 0; i < 6; i++)
                if (l_en[i]) r[13+i] = l_val[i];
        end
        return r;
    endfunction

    function automatic logic exp_hit(input logic [31:0] a);
        return (a >= 32'h6000_0000 && a <= 32'h6007_FFFF && !irq_ctx && l_en != 0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Model update at a clock edge from the current inputs.
    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_en[i] = 0; m_val[i] = 0; end
            l_en = 0; l_val = 0; m_act = 0; m_pend = 0; m_ptid = 0;
        end else begin
            if (tbl_we) begin m_en[tbl_idx] = tbl_en; m_val[tbl_idx] = tbl_val; end
            if (ctx_sw) begin
                if (dma_lock) begin m_pend = 1; m_ptid = ctx_tid; end
                else begin m_act = ctx_tid; m_pend = 0; l_en = m_en[m_act]; l_val = m_val[m_act]; end
            end else if (dma_lock) begin
                if (tbl_we && tbl_idx == m_act && m_pend == 0) begin m_pend = 1; m_ptid = m_act; end
            end else if (m_pend != 0) begin
                m_act = m_ptid; m_pend = 0; l_en = m_en[m_act]; l_val = m_val[m_act];
            end else if (tbl_we && tbl_idx == m_act) begin
                l_en = m_en[m_act]; l_val = m_val[m_act];
            end
        end
    endtask

    // Compare outputs, then advance one clock with the model.
    task automatic step(input string tag);
        #1;
        if (rst_n) begin
            chk({tag, " phys"}, phys_addr, exp_phys(bus_addr));
            chk({tag, " hit"}, {31'b0, remap_hit}, {31'b0, exp_hit(bus_addr)});
            chk({tag, " tid"}, {29'b0, active_tid}, m_act[31:0]);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        ctx_sw = 0; tbl_we = 0;
    endtask

    task automatic wr(input string tag, input int idx, input int en, input int val);
        tbl_we = 1; tbl_idx = idx[2:0]; tbl_en = en[5:0]; tbl_val = val[5:0];
        step(tag);
        idle();
    endtask

    task automatic sw(input string tag, input int tid);
        ctx_sw = 1; ctx_tid = tid[2:0];
        step(tag);
        idle();
    endtask

    task automatic probe(input string tag, input int seed);
        for (int k = 0; k < 10; k++) begin
            bus_addr = 32'h6000_0000 + ((k * 32'h2A57 + seed * 32'h1357) & 32'h7FFFF);
            step(tag);
        end
        bus_addr = 32'h6000_0000; step(tag);
        bus_addr = 32'h6007_FFFF; step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; bus_addr = 32'h6000_0000; irq_ctx = 0; ctx_sw = 0; ctx_tid = 0;
        dma_lock = 0; tbl_we = 0; tbl_idx = 0; tbl_en = 0; tbl_val = 0;
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        probe("R1", 1);
        for (int t = 0; t < 8; t++) begin sw("R1", t); probe("R1", t); end

        // Clamp entries: bit18 low, bit18 high, all six, top three, one mid line
        wr("R2", 1, 6'b100000, 6'b000000);
        wr("R2", 2, 6'b100000, 6'b100000);
        wr("R3", 3, 6'b111111, 6'b101010);
        wr("R3", 4, 6'b111000, 6'b010000);
        wr("R2", 5, 6'b000100, 6'b000100);
        sw("R6", 1);
        bus_addr = 32'h6004_0000; #1;
        chk("R3 mirror low", phys_addr, 32'h6000_0000);
        probe("R2", 2);
        sw("R6", 2);
        bus_addr = 32'h6000_1234; #1;
        chk("R3 upper half", phys_addr, 32'h6004_1234);
        probe("R2", 3);
        sw("R6", 3);
        bus_addr = 32'h6007_E010; #1;
        chk("R3 single block", phys_addr, 32'h6005_4010);
        probe("R3", 4);
        sw("R6", 4); probe("R3", 5);
        sw("R6", 5); probe("R9", 6);

        // Outside the region
        bus_addr = 32'h5FFF_FFFF; step("R4");
        bus_addr = 32'h6008_0000; step("R4");
        bus_addr = 32'h0000_2000; step("R4");
        bus_addr = 32'hE007_E000; step("R4");

        // Interrupt context
        irq_ctx = 1; probe("R5", 7); irq_ctx = 0;

        // Lock holds switches; newest pending wins
        sw("R6", 3);
        dma_lock = 1;
        sw("R7", 1); probe("R7", 8);
        sw("R7", 2); step("R7");
        dma_lock = 0; probe("R7", 9);
        dma_lock = 1; sw("R7", 4); step("R7");
        dma_lock = 0; ctx_sw = 1; ctx_tid = 5; step("R7"); idle();
        probe("R7", 10);

        // Write to active entry, unlocked then locked
        wr("R8", 5, 6'b011000, 6'b001000); probe("R8", 11);
        dma_lock = 1; wr("R8", 5, 6'b000011, 6'b000010); probe("R8", 12);
        dma_lock = 0; probe("R8", 13);
        wr("R8", 6, 6'b111111, 6'b000000); probe("R8", 14);

        // Same-cycle write and switch to the same entry
        tbl_we = 1; tbl_idx = 7; tbl_en = 6'b110011; tbl_val = 6'b100001;
        ctx_sw = 1; ctx_tid = 7; step("R10"); idle();
        probe("R10", 15);
        irq_ctx = 1; step("R5"); irq_ctx = 0; step("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule